// File: doc/BRIEF.md
# Interrupt Controller Base and Identifier Register

This block is the per-core control register that locates and configures a local interrupt controller. It holds a 32-bit base word made of four parts: the controller's page address, a global enable, an extended-addressing mode flag and a flag marking the core as the bootstrap processor. Next to it sits the controller's 8-bit identifier, which software may overwrite, and a wider initial identifier supplied on a strap input. The core's control logic writes and reads both registers over a simple one-cycle bus. A core-level reset input restores the base word and the identifier, and a separate designate input moves the bootstrap flag on its own.

Two behaviours tie the identifier to the mode flag. A base write that turns extended mode on discards any identifier software wrote and reloads the strapped value. While extended mode stays on, the identifier the block reports is always the full strapped initial identifier. A strap input also reports whether a controller is present at all. When none is present, a base read shows only the bootstrap flag.

Top module: `intc_base_reg`

## Requirements
- R1: After the power-on reset `rstN`, the base word reads 0xFEE00800 (address 0xFEE00 in bits 31:12, enable in bit 11 set, extended mode in bit 10 clear, bootstrap flag in bit 8 clear), and the identifier equals `initId[7:0]`.
- R2: A `softReset` cycle sets the base word to 0xFEE00800 ORed with the bootstrap flag bit 8 that was held before it. The bootstrap flag is the only field that survives.
- R3: A `softReset` cycle reloads the writable identifier from `initId[7:0]`.
- R4: A base write (`wrSel`=0) stores data bits 31:12, 11, 10 and 8. All other bits of the base word read as zero.
- R5: A base write that sets bit 10 while bit 10 was clear reloads the writable identifier from `initId[7:0]`, discarding any earlier identifier write.
- R6: A base write that clears bit 10, or that leaves it set when it was already set, does not change the writable identifier.
- R7: `effId` equals the full 32-bit `initId` while bit 10 is set. Otherwise it equals the writable identifier, zero-extended.
- R8: A `designateEn` cycle sets bit 8 to `designateBsp` and leaves every other base bit unchanged. If a base write happens in the same cycle, the designate value wins for bit 8.
- R9: While `ctrlPresent` is 0, a base read (`rdSel`=0) returns only bit 8 of the base word, with every other bit zero.
- R10: An identifier write (`wrSel`=1) stores `wrData[7:0]` into the writable identifier.
- R11: When `softReset` coincides with a bus write or a designate cycle, the reset result of R2 and R3 applies and the other requests are dropped.
- R12: `rdData` returns the base word when `rdSel`=0 and a controller is present, and returns `effId` when `rdSel`=1. It is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| softReset | input | 1 | Core-level reset request, one cycle |
| initId | input | 32 | Strapped initial identifier |
| ctrlPresent | input | 1 | Strap: a controller is present |
| designateEn | input | 1 | Update the bootstrap flag this cycle |
| designateBsp | input | 1 | New bootstrap flag value |
| wrEn | input | 1 | Bus write strobe |
| wrSel | input | 1 | Write target: 0 base word, 1 identifier |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 base word, 1 identifier |
| rdData | output | 32 | Read data |
| baseValue | output | 32 | Current base word |
| effId | output | 32 | Effective identifier |

## Verification
The assertions assume that `initId` stays constant between resets, as a strap should. The bench sets it once, before reset is released. The assertions also assume that the control logic raises at most one write target per cycle. The single `wrSel` line guarantees this, and the bench drives every request for exactly one cycle, releasing each strobe just after the clock edge. Same-cycle collisions of `softReset`, writes and designate are driven on purpose, so the assertions' guards on the reset strobe get exercised.

// File: rtl/intc_base_pkg.sv
package intc_base_pkg;

  localparam int BSP_BIT = 8;
  localparam int EXT_BIT = 10;
  localparam int EN_BIT  = 11;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_IDENT = 1'b1
  } regSelT;

  typedef struct packed {
    logic baseWr;
    logic idWr;
    logic softRst;
    logic desig;
    logic desigVal;
  } regStrobeT;

endpackage

// File: rtl/intc_base_ctrl.sv
module intc_base_ctrl
  import intc_base_pkg::*;
(
  input  logic      softReset,
  input  logic      wrEn,
  input  logic      wrSel,
  input  logic      designateEn,
  input  logic      designateBsp,
  output regStrobeT strb
);

  // Reset outranks every other request in the same cycle.
  always_comb begin
    strb          = '0;
    strb.softRst  = softReset;
    if (!softReset) begin
      strb.baseWr   = wrEn && (regSelT'(wrSel) == SEL_BASE);
      strb.idWr     = wrEn && (regSelT'(wrSel) == SEL_IDENT);
      strb.desig    = designateEn;
      strb.desigVal = designateBsp;
    end
  end

endmodule

// File: rtl/intc_base_dp.sv
module intc_base_dp
  import intc_base_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W = 8,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] DEF_ADDR = 20'hFEE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] initId,
  output logic [DATA_W-1:0] baseValue,
  output logic [DATA_W-1:0] effId,
  output logic              bspFlag
);

  localparam int ADDR_LSB = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic              enReg;
  logic              extReg;
  logic              bspReg;
  logic [ID_W-1:0]   idReg;
  logic              extRise;

  assign extRise = strb.baseWr && wrData[EXT_BIT] && !extReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= DEF_ADDR;
      enReg   <= 1'b1;
      extReg  <= 1'b0;
      bspReg  <= 1'b0;
    end else if (strb.softRst) begin
      addrReg <= DEF_ADDR;
      enReg   <= 1'b1;
      extReg  <= 1'b0;
    end else begin
      if (strb.baseWr) begin
        addrReg <= wrData[DATA_W-1:ADDR_LSB];
        enReg   <= wrData[EN_BIT];
        extReg  <= wrData[EXT_BIT];
        bspReg  <= wrData[BSP_BIT];
      end
      if (strb.desig) begin
        bspReg <= strb.desigVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg <= initId[ID_W-1:0];
    end else if (strb.softRst || extRise) begin
      idReg <= initId[ID_W-1:0];
    end else if (strb.idWr) begin
      idReg <= wrData[ID_W-1:0];
    end
  end

  always_comb begin
    baseValue                          = '0;
    baseValue[DATA_W-1:ADDR_LSB]       = addrReg;
    baseValue[EN_BIT]                  = enReg;
    baseValue[EXT_BIT]                 = extReg;
    baseValue[BSP_BIT]                 = bspReg;
  end

  assign effId   = extReg ? initId : {{(DATA_W-ID_W){1'b0}}, idReg};
  assign bspFlag = bspReg;

  // R2: reset restores address, enable, mode and keeps the bootstrap flag
  a_r2_soft_reset_base: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (addrReg == DEF_ADDR) && enReg && !extReg
                     && (bspReg == $past(bspReg)));

  // R3: reset reloads the identifier
  a_r3_soft_reset_id: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (idReg == $past(initId[ID_W-1:0])));

  // R5: turning extended mode on reloads the identifier
  a_r5_ext_entry_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strb.baseWr && !strb.softRst && wrData[EXT_BIT] && !extReg)
      |=> (idReg == $past(initId[ID_W-1:0])));

  // R6: other base writes leave the identifier alone
  a_r6_id_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.baseWr && !strb.softRst && !strb.idWr
     && !(wrData[EXT_BIT] && !extReg)) |=> $stable(idReg));

  // R8: designate decides the bootstrap flag
  a_r8_designate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.desig && !strb.softRst) |=> (bspReg == $past(strb.desigVal)));

endmodule

// File: rtl/intc_base_reg.sv
module intc_base_reg
  import intc_base_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W = 8,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] DEF_ADDR = 20'hFEE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic [DATA_W-1:0] initId,
  input  logic              ctrlPresent,
  input  logic              designateEn,
  input  logic              designateBsp,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] baseValue,
  output logic [DATA_W-1:0] effId
);

  regStrobeT   strb;
  logic        bspFlag;
  logic [DATA_W-1:0] absentWord;

  intc_base_ctrl u_ctrl (
    .softReset   (softReset),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .designateEn (designateEn),
    .designateBsp(designateBsp),
    .strb        (strb)
  );

  intc_base_dp #(
    .DATA_W  (DATA_W),
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W),
    .DEF_ADDR(DEF_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .initId   (initId),
    .baseValue(baseValue),
    .effId    (effId),
    .bspFlag  (bspFlag)
  );

  always_comb begin
    absentWord          = '0;
    absentWord[BSP_BIT] = bspFlag;
  end

  always_comb begin
    if (regSelT'(rdSel) == SEL_IDENT) rdData = effId;
    else if (ctrlPresent)             rdData = baseValue;
    else                              rdData = absentWord;
  end

  // R9: with no controller, only the bootstrap flag is visible
  a_r9_absent_read: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlPresent && !rdSel) |-> ((rdData & ~(32'h1 << BSP_BIT)) == '0));

endmodule

// File: tb/intc_base_reg_test.sv
module intc_base_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] INIT_ID = 32'hA5A5_0137;

  typedef struct {
    string       req;
    logic [31:0] expBase;
    logic [31:0] expEff;
    logic [31:0] expRd;
  } expItemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softReset = 1'b0;
  logic [31:0] initId = INIT_ID;
  logic ctrlPresent = 1'b1;
  logic designateEn = 1'b0;
  logic designateBsp = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic rdSel = 1'b0;
  logic [31:0] rdData, baseValue, effId;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItemT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_base_reg uut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .initId(initId),
    .ctrlPresent(ctrlPresent), .designateEn(designateEn),
    .designateBsp(designateBsp), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .baseValue(baseValue), .effId(effId)
  );

  task automatic compare(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pop expectations and compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItemT it;
        it = expQ.pop_front();
        compare(it.req, "baseValue", baseValue, it.expBase);
        compare(it.req, "effId", effId, it.expEff);
        compare(it.req, "rdData", rdData, it.expRd);
      end
    end
  end

  // Driver: one request cycle, then queue the expected result
  task automatic step(bit doWr, bit sel, logic [31:0] data, bit doDes, bit desVal,
                      bit doSoft, bit rdS, string req,
                      logic [31:0] eBase, logic [31:0] eEff, logic [31:0] eRd);
    expItemT it;
    wrEn = doWr; wrSel = sel; wrData = data;
    designateEn = doDes; designateBsp = desVal; softReset = doSoft;
    @(posedge clk);
    #1;
    wrEn = 1'b0; designateEn = 1'b0; softReset = 1'b0;
    rdSel = rdS;
    it.req = req; it.expBase = eBase; it.expEff = eEff; it.expRd = eRd;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: power-on state
    step(0,0,0, 0,0, 0, 0, "R1", 32'hFEE00800, 32'h37, 32'hFEE00800);
    // R10: identifier write keeps low byte
    step(1,1,32'h1C2, 0,0, 0, 1, "R10", 32'hFEE00800, 32'hC2, 32'hC2);
    // R4 R5 R7: base write with reserved bits, enters extended mode
    step(1,0,32'h1234_5FFF, 0,0, 0, 0, "R4_R5", 32'h12345D00, INIT_ID, 32'h12345D00);
    // R7: id write in extended mode not visible
    step(1,1,32'h55, 0,0, 0, 1, "R7", 32'h12345D00, INIT_ID, INIT_ID);
    // R6: clearing extended mode keeps id 0x55
    step(1,0,32'h800, 0,0, 0, 1, "R6", 32'h800, 32'h55, 32'h55);
    // R5: entering again reloads id
    step(1,0,32'hC00, 0,0, 0, 1, "R5", 32'hC00, INIT_ID, INIT_ID);
    step(1,1,32'h99, 0,0, 0, 1, "R7", 32'hC00, INIT_ID, INIT_ID);
    // R6: write with mode already set keeps id
    step(1,0,32'hC00, 0,0, 0, 1, "R6", 32'hC00, INIT_ID, INIT_ID);
    step(1,0,32'h800, 0,0, 0, 1, "R6", 32'h800, 32'h99, 32'h99);
    // R8: designate alone
    step(0,0,0, 1,1, 0, 0, "R8", 32'h900, 32'h99, 32'h900);
    // R8: designate beats same-cycle base write on bit 8
    step(1,0,32'h0, 1,1, 0, 0, "R8", 32'h100, 32'h99, 32'h100);
    step(1,0,32'h0, 1,0, 0, 0, "R8", 32'h0, 32'h99, 32'h0);
    step(1,0,32'hABCD_E500, 0,0, 0, 0, "R4", 32'hABCDE500, INIT_ID, 32'hABCDE500);
    step(1,1,32'h11, 0,0, 0, 1, "R10", 32'hABCDE500, INIT_ID, INIT_ID);
    // R2 R3: soft reset keeps bootstrap flag 1, reloads id
    step(0,0,0, 0,0, 1, 1, "R2_R3", 32'hFEE00900, 32'h37, 32'h37);
    step(0,0,0, 1,0, 0, 0, "R8", 32'hFEE00800, 32'h37, 32'hFEE00800);
    step(0,0,0, 0,0, 1, 0, "R2", 32'hFEE00800, 32'h37, 32'hFEE00800);
    // R11: soft reset wins over write and designate
    step(1,1,32'h77, 0,0, 0, 1, "R10", 32'hFEE00800, 32'h77, 32'h77);
    step(1,0,32'h0000_0C00, 1,1, 1, 1, "R11", 32'hFEE00800, 32'h37, 32'h37);
    // R9: absent controller shows only bootstrap flag
    ctrlPresent = 1'b0;
    step(0,0,0, 1,1, 0, 0, "R9", 32'hFEE00900, 32'h37, 32'h100);
    step(0,0,0, 0,0, 0, 1, "R12", 32'hFEE00900, 32'h37, 32'h37);
    ctrlPresent = 1'b1;
    step(0,0,0, 0,0, 0, 0, "R12", 32'hFEE00900, 32'h37, 32'hFEE00900);
    @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule